// File: doc/BRIEF.md
# PCI Initiator Bus Request and Grant Controller

This block sits between a bridge's upstream queues and the external arbiter of the bus on which the bridge acts as initiator. It raises an active-low request whenever a posted write or a delayed request is waiting and the head entry has been written into its queue in full. It samples the active-low grant and issues a one-cycle start strobe to the initiator state machine. After that it blocks further starts until the initiator reports that the transaction is over.

When the arbiter grants the bus while the block is not requesting, the block enables parking: the address/data, command/byte-enable and parity drivers are held at valid levels. If work becomes ready while the bus is parked, the transaction starts at once, relying on the grant seen in the previous cycle. A retry, disconnect or target-abort termination withdraws the request for a fixed number of clocks (two by default). After that the request returns if work is still waiting.

Top module: `pci_ini_reqgnt`

## Requirements
- R1: While `rst` is high, `req_n` is 1, `start` is 0 and `park_en` is 0 after the next clock edge.
- R2: With no backoff running, `req_n` goes to 0 one clock after `pw_pending` or `dr_pending` is 1 together with `head_queued`, and returns to 1 one clock after that condition ends.
- R3: While `head_queued` is 0, `req_n` is 1 one clock later, whatever the pending flags are.
- R4: A 1 on any of `term_retry`, `term_disc` or `term_tabort` forces `req_n` to 1 for exactly BACKOFF clocks, starting at the next edge. After that `req_n` follows R2 again.
- R5: If `req_n` is 0 and `gnt_n` is 0 at a clock edge while the block is idle and work is ready, `start` is 1 in the cycle after that edge.
- R6: `start` is never 1 in two consecutive cycles. After a start, no new start occurs until `init_done` or a termination input has been seen.
- R7: If `gnt_n` is 0 while `req_n` is 1 and no transaction is starting or in flight, `park_en` is 1 in the following cycle for as long as `gnt_n` stays 0. It drops in the same cycle that `gnt_n` reads 1.
- R8: When the bus is parked and work becomes ready with no backoff running, `start` is 1 one clock later, without a request/grant round trip.
- R9: `park_en` is 0 in a start cycle and while a transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| pw_pending | input | 1 | Posted-write queue holds upstream data |
| dr_pending | input | 1 | Delayed-request queue holds an entry |
| head_queued | input | 1 | Head entry is completely written |
| term_retry | input | 1 | Target retry received (one-cycle pulse) |
| term_disc | input | 1 | Target disconnect received (one-cycle pulse) |
| term_tabort | input | 1 | Target abort received (one-cycle pulse) |
| init_done | input | 1 | Initiator state machine finished the transaction |
| gnt_n | input | 1 | Grant from the arbiter, active low |
| req_n | output | 1 | Request to the arbiter, active low |
| start | output | 1 | One-cycle strobe that starts a transaction |
| park_en | output | 1 | Drive AD, C/BE and PAR to valid levels |

## Verification
The request path is driven with pending flags while the queued flag is both low and high. This separates incomplete entries from ready work, and posted-write from delayed-request sources. Grants are held low across a whole transaction to show that the block waits for completion, and again after `init_done` to show that it restarts. Each of the three termination kinds is pulsed during active requests, and again while the bus is parked, so the backoff length and the parked start after backoff can both be told apart. A long random stretch mixes all inputs against a behavioural model checked every cycle.

// File: rtl/pci_ini_pkg.sv
package pci_ini_pkg;

    parameter int unsigned DEF_BACKOFF = 2;

    typedef struct packed {
        logic retry;
        logic disc;
        logic tabort;
    } term_t;

    typedef struct packed {
        logic pw;
        logic dr;
        logic queued;
    } work_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PARK  = 2'd1,
        PH_START = 2'd2,
        PH_BUSY  = 2'd3
    } phase_e;

    function automatic logic term_any(input term_t t);
        return t.retry | t.disc | t.tabort;
    endfunction

    function automatic logic work_ready(input work_t w);
        return (w.pw | w.dr) & w.queued;
    endfunction

endpackage

// File: rtl/pci_ini_backoff.sv
module pci_ini_backoff
    import pci_ini_pkg::*;
#(
    parameter int unsigned BACKOFF = DEF_BACKOFF
) (
    input  logic  clk,
    input  logic  rst,
    input  term_t term,
    output logic  clear_next
);
    localparam int unsigned CW = $clog2(BACKOFF + 1);
    localparam logic [CW-1:0] LOAD = CW'(BACKOFF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          hit;

    assign hit = term_any(term);

    always_comb begin
        if (hit)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = '0;
    end

    assign clear_next = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R4: a termination loads the full backoff count
    assert_backoff_load_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt_q == LOAD));

    // R4: counter only moves down when no termination arrives
    assert_backoff_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pci_ini_reqgen.sv
module pci_ini_reqgen
    import pci_ini_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  work_t work,
    input  logic  clear_next,
    output logic  ready,
    output logic  req_n
);
    logic req_q;

    assign ready = work_ready(work);

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= 1'b0;
        else
            req_q <= ready & clear_next;
    end

    assign req_n = ~req_q;

    // R3: an entry not yet fully queued never raises the request
    assert_no_req_unqueued_R3: assert property (@(posedge clk) disable iff (rst)
        !work.queued |=> req_n);

    // R4: backoff in progress keeps the request withdrawn
    assert_req_backoff_R4: assert property (@(posedge clk) disable iff (rst)
        !clear_next |=> req_n);

    // R2: no pending source, no request
    assert_req_needs_work_R2: assert property (@(posedge clk) disable iff (rst)
        (!work.pw && !work.dr) |=> req_n);

endmodule

// File: rtl/pci_ini_startctl.sv
module pci_ini_startctl
    import pci_ini_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ready,
    input  logic  clear_next,
    input  logic  req_n,
    input  logic  gnt_n,
    input  term_t term,
    input  logic  init_done,
    output logic  start,
    output logic  park_en
);
    phase_e ph_q;
    phase_e ph_d;
    logic   go_req;
    logic   go_park;
    logic   go;
    logic   ended;

    assign ended   = init_done | term_any(term);
    assign go_req  = (ph_q == PH_IDLE) & ~req_n & ~gnt_n;
    assign go_park = (ph_q == PH_PARK);
    assign go      = (go_req | go_park) & ready & clear_next;

    always_comb begin
        ph_d = ph_q;
        if (go) begin
            ph_d = PH_START;
        end else begin
            unique case (ph_q)
                PH_START: ph_d = PH_BUSY;
                PH_BUSY:  ph_d = ended ? PH_IDLE : PH_BUSY;
                default:  ph_d = (~gnt_n & req_n) ? PH_PARK : PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_IDLE;
        else
            ph_q <= ph_d;
    end

    assign start   = (ph_q == PH_START);
    assign park_en = (ph_q == PH_PARK) & ~gnt_n;

    // R6: start is a single-cycle strobe
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R6: no restart while the initiator is still busy
    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_BUSY && !ended) |=> !start);

    // R9: drivers belong to the initiator on a start
    assert_no_park_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> !park_en);

    // R7: parking requires the grant in the same cycle
    assert_park_gnt_R7: assert property (@(posedge clk) disable iff (rst)
        park_en |-> !gnt_n);

    // R5: start follows a qualified grant
    assert_start_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(start) |-> ($past(ready) && $past(clear_next)));

endmodule

// File: rtl/pci_ini_reqgnt.sv
module pci_ini_reqgnt
    import pci_ini_pkg::*;
#(
    parameter int unsigned BACKOFF = DEF_BACKOFF
) (
    input  logic clk,
    input  logic rst,
    input  logic pw_pending,
    input  logic dr_pending,
    input  logic head_queued,
    input  logic term_retry,
    input  logic term_disc,
    input  logic term_tabort,
    input  logic init_done,
    input  logic gnt_n,
    output logic req_n,
    output logic start,
    output logic park_en
);
    term_t term;
    work_t work;
    logic  clear_next;
    logic  ready;

    assign term = '{retry: term_retry, disc: term_disc, tabort: term_tabort};
    assign work = '{pw: pw_pending, dr: dr_pending, queued: head_queued};

    pci_ini_backoff #(.BACKOFF(BACKOFF)) u_backoff (
        .clk        (clk),
        .rst        (rst),
        .term       (term),
        .clear_next (clear_next)
    );

    pci_ini_reqgen u_reqgen (
        .clk        (clk),
        .rst        (rst),
        .work       (work),
        .clear_next (clear_next),
        .ready      (ready),
        .req_n      (req_n)
    );

    pci_ini_startctl u_startctl (
        .clk        (clk),
        .rst        (rst),
        .ready      (ready),
        .clear_next (clear_next),
        .req_n      (req_n),
        .gnt_n      (gnt_n),
        .term       (term),
        .init_done  (init_done),
        .start      (start),
        .park_en    (park_en)
    );

    // R1: reset leaves the bus untouched
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (req_n && !start && !park_en));

endmodule

// File: tb/pci_ini_reqgnt_test.sv
module pci_ini_reqgnt_test;
    localparam int CLK_PERIOD = 10;
    localparam int BACK = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pw_pending = 0, dr_pending = 0, head_queued = 0;
    logic term_retry = 0, term_disc = 0, term_tabort = 0;
    logic init_done = 0, gnt_n = 1;
    logic req_n, start, park_en;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0;
    bit m_req = 0, m_start = 0, m_park = 0, m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_ini_reqgnt #(.BACKOFF(BACK)) uut (
        .clk(clk), .rst(rst),
        .pw_pending(pw_pending), .dr_pending(dr_pending), .head_queued(head_queued),
        .term_retry(term_retry), .term_disc(term_disc), .term_tabort(term_tabort),
        .init_done(init_done), .gnt_n(gnt_n),
        .req_n(req_n), .start(start), .park_en(park_en)
    );

    always @(posedge clk) begin
        bit rdy, trm, ns, np, nb;
        int nc;
        if (rst) begin
            m_cnt = 0; m_req = 0; m_start = 0; m_park = 0; m_busy = 0;
        end else begin
            rdy = (pw_pending || dr_pending) && head_queued;
            trm = term_retry || term_disc || term_tabort;
            if (trm) nc = BACK;
            else if (m_cnt > 0) nc = m_cnt - 1;
            else nc = 0;
            ns = !m_busy && !m_start && nc == 0 && rdy &&
                 ((m_req && !gnt_n) || m_park);
            np = !gnt_n && !m_req && !m_busy && !m_start && !ns;
            if (m_start) nb = 1;
            else if (init_done || trm) nb = 0;
            else nb = m_busy;
            m_req = rdy && nc == 0;
            m_cnt = nc; m_start = ns; m_park = np; m_busy = nb;
        end
    end

    task automatic check_one(string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check_one("req_n", req_n, !m_req);
        check_one("start", start, m_start);
        check_one("park_en", park_en, m_park && !gnt_n);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_term(int kind);
        term_retry = (kind == 0); term_disc = (kind == 1); term_tabort = (kind == 2);
        cyc();
        term_retry = 0; term_disc = 0; term_tabort = 0;
    endtask

    initial begin
        int starts;
        // R1: reset state
        tag = "R1";
        run(3);
        rst = 0;
        run(2);
        // R3: pending but not fully queued
        tag = "R3";
        pw_pending = 1; head_queued = 0;
        run(4);
        // R2: fully queued posted write, then delayed request alone
        tag = "R2";
        head_queued = 1;
        run(3);
        pw_pending = 0; dr_pending = 1;
        run(2);
        dr_pending = 0;
        run(2);
        dr_pending = 1;
        run(2);
        // R5/R6: grant, single start, hold until done
        tag = "R5";
        gnt_n = 0;
        run(2);
        tag = "R6";
        starts = 0;
        for (int i = 0; i < 6; i++) begin cyc(); if (start) starts++; end
        n_tests++;
        if (starts != 0) begin
            n_fail++;
            $display("FAIL R6 extra starts actual=%0d expected=0", starts);
        end
        init_done = 1; cyc(); init_done = 0;
        run(4);
        gnt_n = 1;
        init_done = 1; cyc(); init_done = 0;
        run(2);
        // R4: each termination kind withdraws the request
        tag = "R4";
        for (int k = 0; k < 3; k++) begin
            pulse_term(k);
            run(4);
        end
        // R7: grant while idle parks the bus; drops with grant
        tag = "R7";
        dr_pending = 0;
        run(2);
        gnt_n = 0;
        run(4);
        gnt_n = 1;
        cyc();
        gnt_n = 0;
        run(2);
        // R8: parked, work arrives
        tag = "R8";
        pw_pending = 1;
        run(2);
        // R9: in flight, no parking
        tag = "R9";
        pw_pending = 0;
        run(3);
        init_done = 1; cyc(); init_done = 0;
        run(3);
        // R4 with parking: backoff then parked start
        tag = "R4";
        pw_pending = 1;
        pulse_term(0);
        run(5);
        init_done = 1; cyc(); init_done = 0;
        // random mix
        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            pw_pending  = ($urandom_range(3) != 0);
            dr_pending  = ($urandom_range(3) == 0);
            head_queued = ($urandom_range(4) != 0);
            gnt_n       = ($urandom_range(2) == 0);
            init_done   = ($urandom_range(5) == 0);
            term_retry  = ($urandom_range(15) == 0);
            term_disc   = ($urandom_range(20) == 0);
            term_tabort = ($urandom_range(30) == 0);
            cyc();
        end
        term_retry = 0; term_disc = 0; term_tabort = 0; init_done = 0;
        run(3);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule